// File: doc/BRIEF.md
# Two-Channel Downstream Selector with Serial-Bus Control

This block is a serial-bus target (I2C protocol, target side only) that owns a single control byte. The low three bits of that byte decide which of two downstream channels is switched on, or that neither is. A selection written by the bus controller is held inside the block and reaches the channel-enable outputs only when the controller ends the transfer with a STOP. By then all downstream lines are idle, so enabling a channel cannot create a false bus condition.

The block also collects two active-low interrupt lines, one per downstream channel. It combines them into one active-low request toward the host. When the controller reads the control byte, the block reports the live state of both lines, whether or not their channel is selected. The controller can then find the interrupting channel, select it and service it.

The SCL and SDA inputs are oversampled by the system clock. The SDA output is a pull-low enable for an open-drain pad.

Top module: `i2c_chsel_ctrl`

## Requirements
- R1: The 7-bit target address is 1110 followed by the three strap bits `addr_strap_i[2:0]`, and the eighth bit is R/W (1 read, 0 write). A matching address is acknowledged. A non-matching address is not acknowledged, and the block then ignores the bus (no ACK, no SDA pull, no register change) until the next START.
- R2: In a write transfer, every data byte is acknowledged and loaded into the control register, so the last byte of the transfer is the one kept.
- R3: Selection decode uses control bits [2:0]. Bit 2 = 0 enables no channel. Bit 2 = 1 with bit 0 = 0 enables channel 0 only (`ch_en_o` = 01). Bit 2 = 1 with bit 0 = 1 enables channel 1 only (`ch_en_o` = 10). Bit 1 has no effect on the outputs.
- R4: `ch_en_o` keeps its value while a write is in progress. It takes the newly written selection only after a STOP (SDA rising while SCL is high).
- R5: After reset the control register is zero, `ch_en_o` is 00, SDA is released and the protocol engine is idle.
- R6: `irq_n_o` is low whenever either `irq_n_i` bit is low, for both selected and unselected channels, and high when both are high.
- R7: A read returns, MSB first, a status byte laid out as follows: bits [2:0] hold the stored selection, bit 4 is 1 when channel 0's interrupt line is low, bit 5 is 1 when channel 1's line is low, and bits 7, 6 and 3 are 0. The interrupt bits are sampled when each byte's transmission begins, and both may be 1 together.
- R8: Written values of bits 4 and 5 (and 7, 6, 3) do not change the stored state. A later read returns only the written bits [2:0] plus live interrupt flags.
- R9: During a read the block changes SDA only while SCL is low and releases SDA for the controller's ACK bit. After an ACK it sends another status byte. After a NACK it leaves SDA released until the next START.
- R10: A repeated START (START without a prior STOP) aborts the current transfer and restarts address reception.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, oversampling the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| addr_strap_i | input | 3 | Low three address bits from strap pins |
| irq_n_i | input | 2 | Active-low interrupt from channel 0 (bit 0) and channel 1 (bit 1) |
| sda_pull_o | output | 1 | 1 pulls SDA low (open-drain enable) |
| ch_en_o | output | 2 | Channel enables, bit 0 for channel 0, bit 1 for channel 1 |
| irq_n_o | output | 1 | Active-low combined interrupt request (open-drain style) |

## Verification
The bench builds the block with its default parameters: fixed address upper part 1110 and two synchronizer stages on the bus lines and interrupt inputs. This keeps the full address space of the strap pins in reach by driving `addr_strap_i` to all eight values at run time, and it exercises both matching and deliberately corrupted addresses. With the bit period set to forty system clocks, the three-cycle synchronizer latency leaves wide margins. The directed and random transfers can therefore cover repeated STARTs, multi-byte writes, ACK/NACK endings of reads, and every combination of the two interrupt lines.

// File: rtl/chsel_pkg.sv
package chsel_pkg;
  localparam int CH_NUM = 2;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WR,
    ST_WR_ACK,
    ST_RD,
    ST_RD_ACK
  } tgt_state_e;

  // Bit 2 = enable, bit 0 = channel index, bit 1 unused.
  function automatic logic [CH_NUM-1:0] decode_sel(input logic [2:0] sel);
    return {sel[2] & sel[0], sel[2] & ~sel[0]};
  endfunction
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] scl_sh_q, sda_sh_q;
  logic              scl_prev_q, sda_prev_q;
  logic              scl_s, sda_s;

  assign scl_s = scl_sh_q[STAGES-1];
  assign sda_s = sda_sh_q[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sh_q   <= '1;
      sda_sh_q   <= '1;
      scl_prev_q <= 1'b1;
      sda_prev_q <= 1'b1;
    end else begin
      scl_sh_q   <= {scl_sh_q[STAGES-2:0], scl_i};
      sda_sh_q   <= {sda_sh_q[STAGES-2:0], sda_i};
      scl_prev_q <= scl_s;
      sda_prev_q <= sda_s;
    end
  end

  assign sda_o      = sda_s;
  assign scl_rise_o = scl_s & ~scl_prev_q;
  assign scl_fall_o = ~scl_s & scl_prev_q;
  assign start_o    = scl_s & scl_prev_q & sda_prev_q & ~sda_s;
  assign stop_o     = scl_s & scl_prev_q & ~sda_prev_q & sda_s;
endmodule

// File: rtl/i2c_target_fsm.sv
module i2c_target_fsm
  import chsel_pkg::*;
#(
  parameter logic [3:0] ADDR_HI = 4'b1110
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sda_i,
  input  logic       scl_rise_i,
  input  logic       scl_fall_i,
  input  logic       start_i,
  input  logic       stop_i,
  input  logic [2:0] strap_i,
  input  logic [7:0] status_i,
  output logic       wr_en_o,
  output logic [2:0] wr_sel_o,
  output logic       sda_pull_o
);
  localparam int CNT_W = 4;
  localparam logic [CNT_W-1:0] BYTE_BITS = CNT_W'(8);
  localparam logic [CNT_W-1:0] LAST_TX   = CNT_W'(7);

  tgt_state_e       state_q, state_d;
  logic [CNT_W-1:0] bitcnt_q, bitcnt_d;
  logic [7:0]       shreg_q, shreg_d;
  logic             rw_q, rw_d;
  logic             ack_q, ack_d;
  logic             pull_q, pull_d;
  logic             wr_en;

  always_comb begin
    state_d  = state_q;
    bitcnt_d = bitcnt_q;
    shreg_d  = shreg_q;
    rw_d     = rw_q;
    ack_d    = ack_q;
    pull_d   = pull_q;
    wr_en    = 1'b0;
    if (stop_i) begin
      state_d = ST_IDLE;
      pull_d  = 1'b0;
    end else if (start_i) begin
      state_d  = ST_ADDR;
      bitcnt_d = '0;
      pull_d   = 1'b0;
    end else begin
      unique case (state_q)
        ST_ADDR, ST_WR: begin
          if (scl_rise_i && bitcnt_q < BYTE_BITS) begin
            shreg_d  = {shreg_q[6:0], sda_i};
            bitcnt_d = bitcnt_q + 1'b1;
          end else if (scl_fall_i && bitcnt_q == BYTE_BITS) begin
            if (state_q == ST_WR) begin
              wr_en   = 1'b1;
              pull_d  = 1'b1;
              state_d = ST_WR_ACK;
            end else if (shreg_q[7:1] == {ADDR_HI, strap_i}) begin
              rw_d    = shreg_q[0];
              pull_d  = 1'b1;
              state_d = ST_ADDR_ACK;
            end else begin
              state_d = ST_IDLE;
            end
          end
        end
        ST_ADDR_ACK: begin
          if (scl_fall_i) begin
            bitcnt_d = '0;
            if (rw_q) begin
              shreg_d = status_i;
              pull_d  = ~status_i[7];
              state_d = ST_RD;
            end else begin
              pull_d  = 1'b0;
              state_d = ST_WR;
            end
          end
        end
        ST_WR_ACK: begin
          if (scl_fall_i) begin
            pull_d   = 1'b0;
            bitcnt_d = '0;
            state_d  = ST_WR;
          end
        end
        ST_RD: begin
          if (scl_fall_i) begin
            if (bitcnt_q == LAST_TX) begin
              pull_d  = 1'b0;
              state_d = ST_RD_ACK;
            end else begin
              bitcnt_d = bitcnt_q + 1'b1;
              shreg_d  = {shreg_q[6:0], 1'b0};
              pull_d   = ~shreg_q[6];
            end
          end
        end
        ST_RD_ACK: begin
          if (scl_rise_i) begin
            ack_d = ~sda_i;
          end else if (scl_fall_i) begin
            if (ack_q) begin
              shreg_d  = status_i;
              pull_d   = ~status_i[7];
              bitcnt_d = '0;
              state_d  = ST_RD;
            end else begin
              state_d = ST_IDLE;
            end
          end
        end
        default: begin
          pull_d = 1'b0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      bitcnt_q <= '0;
      shreg_q  <= '0;
      rw_q     <= 1'b0;
      ack_q    <= 1'b0;
      pull_q   <= 1'b0;
    end else begin
      state_q  <= state_d;
      bitcnt_q <= bitcnt_d;
      shreg_q  <= shreg_d;
      rw_q     <= rw_d;
      ack_q    <= ack_d;
      pull_q   <= pull_d;
    end
  end

  assign wr_en_o    = wr_en;
  assign wr_sel_o   = shreg_q[2:0];
  assign sda_pull_o = pull_q;

  // R1: an idle or ignoring target never holds SDA low
  a_r1_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE) |-> !pull_q);
  // R2: every stored data byte is followed by an ACK drive
  a_r2_write_acked: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> pull_q);
  // R9: a NACK from the controller returns the engine to idle
  a_r9_nack_ends: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RD_ACK && scl_fall_i && !ack_q && !start_i && !stop_i)
      |=> (state_q == ST_IDLE && !pull_q));
  // R10: a START always restarts address reception
  a_r10_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !stop_i) |=> (state_q == ST_ADDR && bitcnt_q == '0));
endmodule

// File: rtl/chsel_ctrl_reg.sv
module chsel_ctrl_reg
  import chsel_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  logic [2:0]        wr_sel_i,
  input  logic              stop_i,
  input  logic [CH_NUM-1:0] irq_n_i,
  output logic [7:0]        status_o,
  output logic [CH_NUM-1:0] ch_en_o,
  output logic              irq_n_o
);
  logic [2:0]        sel_q, sel_d;
  logic [CH_NUM-1:0] en_q, en_d;
  logic [CH_NUM-1:0] irq_sh_q [SYNC_STAGES];

  always_comb begin
    sel_d = sel_q;
    en_d  = en_q;
    if (wr_en_i) sel_d = wr_sel_i;
    if (stop_i)  en_d  = decode_sel(sel_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= '0;
      en_q  <= '0;
    end else begin
      sel_q <= sel_d;
      en_q  <= en_d;
    end
  end

  for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_irq_sync
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq_sh_q[s] <= '1;
      else if (s == 0) irq_sh_q[s] <= irq_n_i;
      else irq_sh_q[s] <= irq_sh_q[(s == 0) ? 0 : s-1];
    end
  end

  assign status_o = {2'b00, ~irq_sh_q[SYNC_STAGES-1], 1'b0, sel_q};
  assign ch_en_o  = en_q;
  assign irq_n_o  = &irq_n_i;

  // R3: at most one channel is ever enabled
  a_r3_one_channel: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(en_q));
  // R4: enables move only in the cycle after a STOP
  a_r4_hold_until_stop: assert property (@(posedge clk) disable iff (!rst_n)
    !stop_i |=> $stable(en_q));
endmodule

// File: rtl/i2c_chsel_ctrl.sv
module i2c_chsel_ctrl
  import chsel_pkg::*;
#(
  parameter logic [3:0] ADDR_HI     = 4'b1110,
  parameter int         SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        scl_i,
  input  logic        sda_i,
  input  logic [2:0]  addr_strap_i,
  input  logic [1:0]  irq_n_i,
  output logic        sda_pull_o,
  output logic [1:0]  ch_en_o,
  output logic        irq_n_o
);
  logic       sda_s, scl_rise, scl_fall, start_evt, stop_evt;
  logic       wr_en;
  logic [2:0] wr_sel;
  logic [7:0] status;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .sda_o      (sda_s),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (start_evt),
    .stop_o     (stop_evt)
  );

  i2c_target_fsm #(.ADDR_HI(ADDR_HI)) fsm_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .sda_i      (sda_s),
    .scl_rise_i (scl_rise),
    .scl_fall_i (scl_fall),
    .start_i    (start_evt),
    .stop_i     (stop_evt),
    .strap_i    (addr_strap_i),
    .status_i   (status),
    .wr_en_o    (wr_en),
    .wr_sel_o   (wr_sel),
    .sda_pull_o (sda_pull_o)
  );

  chsel_ctrl_reg #(.SYNC_STAGES(SYNC_STAGES)) reg_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en_i  (wr_en),
    .wr_sel_i (wr_sel),
    .stop_i   (stop_evt),
    .irq_n_i  (irq_n_i),
    .status_o (status),
    .ch_en_o  (ch_en_o),
    .irq_n_o  (irq_n_o)
  );
endmodule

// File: tb/i2c_chsel_ctrl_tb_top.sv
module i2c_chsel_ctrl_tb_top;
  localparam int Q = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       scl, sda_m;
  logic [2:0] strap;
  logic [1:0] irq_n;
  logic       sda_pull;
  logic [1:0] ch_en;
  logic       irq_n_out;
  logic       sda_bus;

  int n_cmp = 0;
  int n_bad = 0;
  logic [2:0] sel_m;
  logic [1:0] en_m;

  always #5 clk = ~clk;
  assign sda_bus = sda_m & ~sda_pull;

  i2c_chsel_ctrl dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .scl_i        (scl),
    .sda_i        (sda_bus),
    .addr_strap_i (strap),
    .irq_n_i      (irq_n),
    .sda_pull_o   (sda_pull),
    .ch_en_o      (ch_en),
    .irq_n_o      (irq_n_out)
  );

  function automatic logic [1:0] exp_en(input logic [2:0] s);
    if (!s[2]) return 2'b00;
    return s[0] ? 2'b10 : 2'b01;
  endfunction

  function automatic logic [7:0] exp_status(input logic [2:0] s, input logic [1:0] irq);
    return {2'b00, ~irq[1], ~irq[0], 1'b0, s};
  endfunction

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wq(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wq(Q);
    scl = 1'b1;   wq(Q);
    sda_m = 1'b0; wq(Q);
    scl = 1'b0;   wq(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wq(Q);
    scl = 1'b1;   wq(Q);
    sda_m = 1'b1; wq(2*Q);
  endtask

  task automatic put_bit(input logic b);
    sda_m = b; wq(Q);
    scl = 1'b1; wq(2*Q);
    scl = 1'b0; wq(Q);
  endtask

  task automatic get_bit(output logic b);
    sda_m = 1'b1; wq(Q);
    scl = 1'b1;   wq(Q);
    b = sda_bus;  wq(Q);
    scl = 1'b0;   wq(Q);
  endtask

  task automatic send_byte(input logic [7:0] d, output logic ack);
    logic a;
    for (int i = 7; i >= 0; i--) put_bit(d[i]);
    get_bit(a);
    ack = ~a;
  endtask

  task automatic recv_byte(input logic give_ack, output logic [7:0] d);
    for (int i = 7; i >= 0; i--) get_bit(d[i]);
    put_bit(~give_ack);
  endtask

  function automatic logic [7:0] addr_byte(input logic [2:0] st, input logic rd);
    return {4'b1110, st, rd};
  endfunction

  // Full write with correct address; returns ch_en seen before the STOP.
  task automatic write_sel(input logic [7:0] d, input string req);
    logic ack;
    bus_start();
    send_byte(addr_byte(strap, 1'b0), ack);
    chk({req, " addr ack (R1)"}, {7'd0, ack}, 8'd1);
    send_byte(d, ack);
    chk({req, " data ack (R2)"}, {7'd0, ack}, 8'd1);
    sel_m = d[2:0];
    chk({req, " held before STOP (R4)"}, {6'd0, ch_en}, {6'd0, en_m});
    bus_stop();
    en_m = exp_en(sel_m);
    chk({req, " enable after STOP (R3)"}, {6'd0, ch_en}, {6'd0, en_m});
  endtask

  task automatic read_status(input int nbytes, input string req);
    logic ack;
    logic [7:0] d;
    bus_start();
    send_byte(addr_byte(strap, 1'b1), ack);
    chk({req, " read addr ack (R1)"}, {7'd0, ack}, 8'd1);
    for (int i = 0; i < nbytes; i++) begin
      recv_byte(i != nbytes-1, d);
      chk({req, " status (R7)"}, d, exp_status(sel_m, irq_n));
    end
    bus_stop();
  endtask

  initial begin
    logic ack;
    logic [7:0] d;
    logic [7:0] a;
    int rnd;
    rnd = $urandom(32'd4242);
    scl = 1'b1; sda_m = 1'b1; strap = 3'b000; irq_n = 2'b11;
    sel_m = 3'b000; en_m = 2'b00;
    rst_n = 1'b0;
    wq(5);
    rst_n = 1'b1;
    wq(5);

    chk("reset ch_en (R5)", {6'd0, ch_en}, 8'd0);
    chk("reset sda (R5)", {7'd0, sda_pull}, 8'd0);
    chk("reset irq (R6)", {7'd0, irq_n_out}, 8'd1);
    read_status(1, "reset");

    strap = 3'b101;
    write_sel(8'h04, "sel ch0");
    read_status(1, "sel ch0");
    write_sel(8'h35, "ro bits R8");
    read_status(2, "ro bits R8");
    write_sel(8'h06, "bit1 ignored R3");
    write_sel(8'h00, "none");

    // R2: several bytes, last one kept
    bus_start();
    send_byte(addr_byte(strap, 1'b0), ack);
    send_byte(8'h05, ack);
    send_byte(8'h04, ack);
    send_byte(8'h07, ack);
    chk("multi-byte last ack (R2)", {7'd0, ack}, 8'd1);
    bus_stop();
    sel_m = 3'b111; en_m = exp_en(sel_m);
    chk("multi-byte last wins (R2)", {6'd0, ch_en}, {6'd0, en_m});

    // R1: wrong address ignored
    bus_start();
    send_byte(addr_byte(strap ^ 3'b010, 1'b0), ack);
    chk("wrong addr no ack (R1)", {7'd0, ack}, 8'd0);
    send_byte(8'h04, ack);
    chk("ignored data no ack (R1)", {7'd0, ack}, 8'd0);
    bus_stop();
    chk("wrong addr no change (R1)", {6'd0, ch_en}, {6'd0, en_m});
    read_status(1, "after wrong addr R1");

    // R10: repeated START turns a write into a read without applying
    bus_start();
    send_byte(addr_byte(strap, 1'b0), ack);
    send_byte(8'h04, ack);
    sel_m = 3'b100;
    bus_start();
    send_byte(addr_byte(strap, 1'b1), ack);
    chk("restart addr ack (R10)", {7'd0, ack}, 8'd1);
    recv_byte(1'b0, d);
    chk("restart read (R10)", d, exp_status(sel_m, irq_n));
    chk("restart no enable yet (R4)", {6'd0, ch_en}, {6'd0, en_m});
    // R9: after NACK the target stays released
    recv_byte(1'b0, d);
    chk("after NACK released (R9)", d, 8'hFF);
    bus_stop();
    en_m = exp_en(sel_m);
    chk("restart then stop (R4)", {6'd0, ch_en}, {6'd0, en_m});

    // R6/R7: interrupts on unselected and selected channels
    irq_n = 2'b01; wq(4);
    chk("irq ch1 unselected (R6)", {7'd0, irq_n_out}, 8'd0);
    read_status(1, "irq ch1 R7");
    irq_n = 2'b00; wq(4);
    chk("irq both (R6)", {7'd0, irq_n_out}, 8'd0);
    read_status(2, "irq both R7");
    irq_n = 2'b10; wq(4);
    read_status(1, "irq ch0 R7");
    irq_n = 2'b11; wq(4);
    chk("irq clear (R6)", {7'd0, irq_n_out}, 8'd1);

    // Random transfers
    for (int t = 0; t < 40; t++) begin
      logic good, rd;
      int nb;
      strap = 3'($urandom);
      irq_n = 2'($urandom);
      wq(4);
      chk("rand irq (R6)", {7'd0, irq_n_out}, {7'd0, &irq_n});
      good = ($urandom % 4) != 0;
      rd = 1'($urandom);
      nb = 1 + int'($urandom % 3);
      a = addr_byte(strap, rd);
      if (!good) a = a ^ (8'h02 << ($urandom % 7));
      bus_start();
      send_byte(a, ack);
      chk("rand addr ack (R1)", {7'd0, ack}, {7'd0, good});
      for (int i = 0; i < nb; i++) begin
        if (rd && good) begin
          recv_byte(i != nb-1, d);
          chk("rand status (R7)", d, exp_status(sel_m, irq_n));
        end else begin
          d = 8'($urandom);
          send_byte(d, ack);
          chk("rand data ack (R2)", {7'd0, ack}, {7'd0, good});
          if (good) sel_m = d[2:0];
        end
      end
      chk("rand held (R4)", {6'd0, ch_en}, {6'd0, en_m});
      bus_stop();
      en_m = exp_en(sel_m);
      chk("rand enable (R3)", {6'd0, ch_en}, {6'd0, en_m});
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule